// File: doc/BRIEF.md
# Serial port flag and interrupt controller

This block keeps the control bits and status flags of a byte-oriented asynchronous serial port. It raises the port's three interrupt lines and tells the transmit shifter when it may take the next byte. A processor programs three control bits through a control write. It polls the status byte through a status read. It retires flags with a status write, which may clear a flag only after a read has seen that flag at 1.

The shifters report events as single-cycle strobes. One says the transmit shifter has taken the byte from the holding register. One says a received byte has landed in the receive holding register. Three others report overrun, framing and parity errors. A transmit-side state machine tracks the holding register and has four states. TXS_OFF means the transmitter is disabled. TXS_EMPTY means the holding register is free. TXS_STALL means the processor has claimed the register but has not yet written data. TXS_LOADED means a byte has been handed to the shifter and the block is waiting for it to be taken.

The transitions are these. OFF goes to EMPTY when the transmit enable reads 1. Any state goes to OFF when the transmit enable reads 0. EMPTY goes to LOADED when the empty flag is cleared and fresh data exists. EMPTY goes to STALL when the empty flag is cleared without fresh data. STALL goes to LOADED when data is written. STALL or LOADED goes back to EMPTY on the shifter's take strobe. Every entry into LOADED emits the start pulse.

Top module: `serial_flag_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, the status byte reads 0x80, and all three interrupt lines and the start output are 0.
- R2: The control byte carries the transmit interrupt enable at bit 7, the receive interrupt enable at bit 6 and the transmit enable at bit 5. A control write stores these bits, they read back in the next cycle, and the other bits read 0.
- R3: The status byte shows transmit-empty at bit 7, receive-full at bit 6, overrun at bit 5, framing at bit 4 and parity at bit 3. Bits 2..0 read 0. The receive strobe sets receive-full and each error strobe sets its own flag, all visible in the next cycle.
- R4: A status write of 0 to a flag that is not armed leaves the flag unchanged. A status write of 1 never changes any flag.
- R5: A status read arms each flag that it returns as 1 and disarms each flag that it returns as 0. The next status write consumes every armed bit, so a second write of 0 without a new read changes nothing.
- R6: When a hardware set event and an armed clear reach the same flag in the same cycle, the flag stays at 1.
- R7: While the transmit enable is 0, transmit-empty reads 1 (from the cycle after the enable is written to 0) and a clear of it has no effect.
- R8: With the transmit enable at 1, clearing an armed transmit-empty flag after data was written to the holding register makes transmit-empty read 0 and pulses the start output high for exactly one cycle, in the cycle after the clearing write.
- R9: If transmit-empty is cleared when no data was written since the last start, the start output stays 0. The start pulse follows in the cycle after the next holding-register write.
- R10: The transmit interrupt line is a registered level, equal one cycle later to the transmit interrupt enable ANDed with the transmit-empty status bit.
- R11: The receive-full interrupt line equals one cycle later the receive interrupt enable ANDed with receive-full. The receive-error interrupt line equals one cycle later the same enable ANDed with the OR of the three error flags. Writing the enable to 0 drops both lines while the flags stay set.
- R12: The take strobe from the transmit shifter sets transmit-empty to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read value |
| sts_rd | input | 1 | Status read strobe (arms flags seen at 1) |
| sts_rdata | output | 8 | Status byte read value |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 8 | Status write data (0 clears an armed flag) |
| hold_wr | input | 1 | Processor wrote the transmit holding register |
| tx_take | input | 1 | Transmit shifter took the holding register |
| rx_land | input | 1 | Received byte moved into the receive holding register |
| err_ovr | input | 1 | Overrun error strobe |
| err_frm | input | 1 | Framing error strobe |
| err_par | input | 1 | Parity error strobe |
| irq_tx_empty | output | 1 | Transmit-empty interrupt level |
| irq_rx_full | output | 1 | Receive-full interrupt level |
| irq_rx_err | output | 1 | Receive-error interrupt level |
| tx_start | output | 1 | One-cycle start pulse to the transmit shifter |

## Verification
A wrong armed bit shows up at the status write that follows the read. A flag that clears without a read first, or that fails to clear after one, is visible in the status byte one cycle after that write. A wrong transmit state shows in the same cycle as a missing, late or doubled start pulse, or as a transmit-empty bit that disagrees with the enable. Any flag error reaches the interrupt lines one cycle later, because each line is a registered copy of an enable ANDed with status.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int BYTE_W   = 8;
    localparam int CTL_TIE  = 7;
    localparam int CTL_RIE  = 6;
    localparam int CTL_TE   = 5;
    localparam int STS_TXE  = 7;
    localparam int STS_RXF  = 6;
    localparam int N_RXFLAG = 4;   // receive-full plus three error flags

    typedef enum logic [1:0] {
        TXS_OFF    = 2'd0,
        TXS_EMPTY  = 2'd1,
        TXS_STALL  = 2'd2,
        TXS_LOADED = 2'd3
    } tx_state_t;
endpackage

// File: rtl/sfc_flag_cell.sv
module sfc_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic rd_ev,
    input  logic wr_ev,
    input  logic wr_bit,
    output logic flag
);
    logic armed_q;
    logic flag_q;

    // arming follows what the read returned; a write consumes it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      armed_q <= 1'b0;
        else if (rd_ev)  armed_q <= flag_q;
        else if (wr_ev)  armed_q <= 1'b0;
    end

    // hardware set has priority over the processor clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              flag_q <= 1'b0;
        else if (set_ev)                         flag_q <= 1'b1;
        else if (wr_ev && armed_q && !wr_bit)    flag_q <= 1'b0;
    end

    assign flag = flag_q;
endmodule

// File: rtl/sfc_tx_fsm.sv
module sfc_tx_fsm
    import sfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic sts_rd,
    input  logic sts_wr,
    input  logic wr_txe_bit,
    input  logic hold_wr,
    input  logic tx_take,
    output logic txe,
    output logic tx_start
);
    tx_state_t state_q, state_d;
    logic      armed_q;
    logic      fresh_q;
    logic      start_q;
    logic      txe_int;
    logic      clear_req;

    assign clear_req = sts_wr && armed_q && !wr_txe_bit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXS_OFF: begin
                if (tx_en) state_d = TXS_EMPTY;
            end
            TXS_EMPTY: begin
                if (!tx_en)                              state_d = TXS_OFF;
                else if (tx_take)                        state_d = TXS_EMPTY;
                else if (clear_req && (fresh_q || hold_wr)) state_d = TXS_LOADED;
                else if (clear_req)                      state_d = TXS_STALL;
            end
            TXS_STALL: begin
                if (!tx_en)        state_d = TXS_OFF;
                else if (tx_take)  state_d = TXS_EMPTY;
                else if (hold_wr)  state_d = TXS_LOADED;
            end
            TXS_LOADED: begin
                if (!tx_en)        state_d = TXS_OFF;
                else if (tx_take)  state_d = TXS_EMPTY;
            end
            default: state_d = TXS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TXS_OFF;
        else        state_q <= state_d;
    end

    // output decode of the current state
    always_comb begin
        unique case (state_q)
            TXS_STALL, TXS_LOADED: txe_int = 1'b0;
            default:               txe_int = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            fresh_q <= 1'b0;
            start_q <= 1'b0;
        end else begin
            if (sts_rd)      armed_q <= txe;
            else if (sts_wr) armed_q <= 1'b0;

            if (state_d == TXS_LOADED && state_q != TXS_LOADED) fresh_q <= 1'b0;
            else if (hold_wr)                                   fresh_q <= 1'b1;

            start_q <= (state_d == TXS_LOADED) && (state_q != TXS_LOADED);
        end
    end

    assign txe      = txe_int || !tx_en;
    assign tx_start = start_q;
endmodule

// File: rtl/sfc_irq_out.sv
module sfc_irq_out (
    input  logic clk,
    input  logic rst_n,
    input  logic tie,
    input  logic rie,
    input  logic txe,
    input  logic rxf,
    input  logic any_err,
    output logic irq_tx,
    output logic irq_rx,
    output logic irq_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_tx  <= 1'b0;
            irq_rx  <= 1'b0;
            irq_err <= 1'b0;
        end else begin
            irq_tx  <= tie && txe;
            irq_rx  <= rie && rxf;
            irq_err <= rie && any_err;
        end
    end
endmodule

// File: rtl/serial_flag_ctrl.sv
module serial_flag_ctrl
    import sfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] ctl_wdata,
    output logic [BYTE_W-1:0] ctl_rdata,
    input  logic              sts_rd,
    output logic [BYTE_W-1:0] sts_rdata,
    input  logic              sts_wr,
    input  logic [BYTE_W-1:0] sts_wdata,
    input  logic              hold_wr,
    input  logic              tx_take,
    input  logic              rx_land,
    input  logic              err_ovr,
    input  logic              err_frm,
    input  logic              err_par,
    output logic              irq_tx_empty,
    output logic              irq_rx_full,
    output logic              irq_rx_err,
    output logic              tx_start
);
    localparam int RX_LSB = STS_RXF - N_RXFLAG + 1;

    logic                tie_q, rie_q, te_q;
    logic                txe;
    logic [N_RXFLAG-1:0] rx_set;
    logic [N_RXFLAG-1:0] rx_flag;
    logic                unused_bits;

    assign unused_bits = ^{ctl_wdata[CTL_TE-1:0], sts_wdata[RX_LSB-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tie_q <= 1'b0;
            rie_q <= 1'b0;
            te_q  <= 1'b0;
        end else if (ctl_wr) begin
            tie_q <= ctl_wdata[CTL_TIE];
            rie_q <= ctl_wdata[CTL_RIE];
            te_q  <= ctl_wdata[CTL_TE];
        end
    end

    // index 3 = receive-full, 2 = overrun, 1 = framing, 0 = parity
    assign rx_set = {rx_land, err_ovr, err_frm, err_par};

    for (genvar gi = 0; gi < N_RXFLAG; gi++) begin : g_rxflag
        sfc_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_ev (rx_set[gi]),
            .rd_ev  (sts_rd),
            .wr_ev  (sts_wr),
            .wr_bit (sts_wdata[RX_LSB + gi]),
            .flag   (rx_flag[gi])
        );
    end

    sfc_tx_fsm u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (te_q),
        .sts_rd     (sts_rd),
        .sts_wr     (sts_wr),
        .wr_txe_bit (sts_wdata[STS_TXE]),
        .hold_wr    (hold_wr),
        .tx_take    (tx_take),
        .txe        (txe),
        .tx_start   (tx_start)
    );

    sfc_irq_out u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tie     (tie_q),
        .rie     (rie_q),
        .txe     (txe),
        .rxf     (rx_flag[N_RXFLAG-1]),
        .any_err (|rx_flag[N_RXFLAG-2:0]),
        .irq_tx  (irq_tx_empty),
        .irq_rx  (irq_rx_full),
        .irq_err (irq_rx_err)
    );

    always_comb begin
        ctl_rdata          = '0;
        ctl_rdata[CTL_TIE] = tie_q;
        ctl_rdata[CTL_RIE] = rie_q;
        ctl_rdata[CTL_TE]  = te_q;
        sts_rdata                    = '0;
        sts_rdata[STS_TXE]           = txe;
        sts_rdata[STS_RXF:RX_LSB]    = rx_flag;
    end
endmodule

// File: rtl/serial_flag_ctrl_chk.sv
module serial_flag_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic [7:0] ctl_wdata,
    input logic [7:0] ctl_rdata,
    input logic       sts_rd,
    input logic [7:0] sts_rdata,
    input logic       sts_wr,
    input logic [7:0] sts_wdata,
    input logic       hold_wr,
    input logic       tx_take,
    input logic       rx_land,
    input logic       err_ovr,
    input logic       err_frm,
    input logic       err_par,
    input logic       irq_tx_empty,
    input logic       irq_rx_full,
    input logic       irq_rx_err,
    input logic       tx_start
);
    a_r7_txe_forced: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[5] |-> sts_rdata[7]);

    a_r10_tx_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_tx_empty == ($past(ctl_rdata[7]) && $past(sts_rdata[7]))));

    a_r11_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[6] |=> (!irq_rx_full && !irq_rx_err));

    a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    a_r8_start_owns_holding: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !sts_rdata[7]);

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rx_land |=> sts_rdata[6]);

    a_r4_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_rdata[6]) |-> $past(sts_wr));

    a_r12_take_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> sts_rdata[7]);
endmodule

bind serial_flag_ctrl serial_flag_ctrl_chk u_chk (.*);

// File: tb/tb_serial_flag_ctrl.sv
module tb_serial_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0, sts_rd = 1'b0, sts_wr = 1'b0;
    logic [7:0] ctl_wdata = '0, sts_wdata = '0;
    logic [7:0] ctl_rdata, sts_rdata;
    logic       hold_wr = 1'b0, tx_take = 1'b0, rx_land = 1'b0;
    logic       err_ovr = 1'b0, err_frm = 1'b0, err_par = 1'b0;
    logic       irq_tx_empty, irq_rx_full, irq_rx_err, tx_start;

    serial_flag_ctrl dut (.*);

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        int         due;
        int         sel;
        logic [7:0] val;
        string      tag;
    } item_t;

    item_t q[$];
    int    cyc   = 0;
    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] pick(int sel);
        case (sel)
            0:       return sts_rdata;
            1:       return ctl_rdata;
            2:       return {5'b0, irq_tx_empty, irq_rx_full, irq_rx_err};
            default: return {7'b0, tx_start};
        endcase
    endfunction

    // monitor: compares every expected item that falls due
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due <= cyc) begin
                total++;
                if (q[i].due < cyc || pick(q[i].sel) !== q[i].val) begin
                    bad++;
                    $display("FAIL %s sel=%0d actual=%02h expected=%02h", q[i].tag,
                             q[i].sel, pick(q[i].sel), q[i].val);
                end
                q.delete(i);
            end
        end
    end

    task automatic expect_at(int d, int sel, logic [7:0] v, string tag);
        q.push_back('{cyc + d, sel, v, tag});
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl_write(logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v; tick(); ctl_wr = 1'b0;
    endtask

    task automatic sts_read();
        sts_rd = 1'b1; tick(); sts_rd = 1'b0;
    endtask

    task automatic sts_write(logic [7:0] v);
        sts_wr = 1'b1; sts_wdata = v; tick(); sts_wr = 1'b0;
    endtask

    task automatic strobe_hold();  hold_wr = 1'b1; tick(); hold_wr = 1'b0; endtask
    task automatic strobe_take();  tx_take = 1'b1; tick(); tx_take = 1'b0; endtask
    task automatic strobe_land();  rx_land = 1'b1; tick(); rx_land = 1'b0; endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        expect_at(1, 0, 8'h80, "R1 status");
        expect_at(1, 1, 8'h00, "R1 control");
        expect_at(1, 2, 8'h00, "R1 irq");
        expect_at(1, 3, 8'h00, "R1 start");
        tick();

        // R2 control layout; R10 tx irq follows one cycle later
        expect_at(1, 1, 8'hE0, "R2 control readback");
        expect_at(2, 2, 8'h04, "R10 tx irq on");
        ctl_write(8'hFF);
        tick();

        // R3 set events, R11 rx irq lines
        expect_at(1, 0, 8'hC0, "R3 receive-full");
        expect_at(2, 2, 8'h06, "R11 rx full irq");
        strobe_land();
        expect_at(1, 0, 8'hD0, "R3 framing");
        expect_at(2, 2, 8'h07, "R11 rx err irq");
        err_frm = 1'b1; tick(); err_frm = 1'b0;
        expect_at(1, 0, 8'hD8, "R3 parity");
        err_par = 1'b1; tick(); err_par = 1'b0;
        expect_at(1, 0, 8'hF8, "R3 overrun");
        err_ovr = 1'b1; tick(); err_ovr = 1'b0;

        // R4 clear without read is ignored
        expect_at(1, 0, 8'hF8, "R4 unarmed clear");
        sts_write(8'h00);

        // R5 arm, clear parity, then second write does nothing
        sts_read();
        expect_at(1, 0, 8'hF0, "R5 armed clear parity");
        sts_write(8'hF7);
        expect_at(1, 0, 8'hF0, "R5 arming consumed");
        sts_write(8'h00);

        // R6 set wins over clear on receive-full
        sts_read();
        expect_at(1, 0, 8'hF0, "R6 set beats clear");
        sts_wr = 1'b1; sts_wdata = 8'hBF; rx_land = 1'b1;
        tick();
        sts_wr = 1'b0; rx_land = 1'b0;

        // R4 write of 1 sets nothing; clear two errors
        sts_read();
        expect_at(1, 0, 8'hC0, "R4 one has no effect");
        expect_at(2, 2, 8'h06, "R11 err irq drops");
        sts_write(8'hC8);
        sts_read();
        expect_at(1, 0, 8'h80, "R5 clear receive-full");
        expect_at(2, 2, 8'h04, "R11 rx irq drops");
        sts_write(8'h80);

        // R8 normal start
        strobe_hold();
        sts_read();
        expect_at(1, 0, 8'h00, "R8 txe cleared");
        expect_at(1, 3, 8'h01, "R8 start pulse");
        expect_at(2, 3, 8'h00, "R8 start one cycle");
        expect_at(2, 2, 8'h00, "R10 tx irq off");
        sts_write(8'h7F);
        tick();
        // R12 shifter take
        expect_at(1, 0, 8'h80, "R12 take sets txe");
        expect_at(2, 2, 8'h04, "R10 tx irq back");
        strobe_take();
        tick();

        // R9 clear with no fresh data, then data write
        sts_read();
        expect_at(1, 0, 8'h00, "R9 txe cleared");
        expect_at(1, 3, 8'h00, "R9 no start");
        sts_write(8'h7F);
        expect_at(2, 3, 8'h00, "R9 still no start");
        tick(2);
        expect_at(1, 3, 8'h01, "R9 start on data");
        expect_at(1, 0, 8'h00, "R9 txe held");
        strobe_hold();
        expect_at(1, 0, 8'h80, "R12 take after stall");
        strobe_take();

        // R6 take and clear in same cycle: txe stays 1, no start
        strobe_hold();
        sts_read();
        expect_at(1, 0, 8'h80, "R6 take beats clear");
        expect_at(1, 3, 8'h00, "R6 no start");
        sts_wr = 1'b1; sts_wdata = 8'h7F; tx_take = 1'b1;
        tick();
        sts_wr = 1'b0; tx_take = 1'b0;
        sts_read();
        expect_at(1, 3, 8'h01, "R8 data kept for start");
        sts_write(8'h7F);
        strobe_take();

        // R10 / R11 enables
        expect_at(2, 2, 8'h00, "R10 tie off");
        ctl_write(8'h60);
        tick();
        expect_at(1, 0, 8'hC0, "R3 receive-full again");
        expect_at(2, 2, 8'h02, "R11 rx irq");
        strobe_land();
        tick();
        expect_at(1, 0, 8'hC0, "R11 flag kept");
        expect_at(2, 2, 8'h00, "R11 rie off drops");
        ctl_write(8'h20);
        tick();

        // R7 transmitter disabled forces txe
        strobe_hold();
        sts_read();
        expect_at(1, 0, 8'h40, "R8 loaded");
        sts_write(8'h7F);
        expect_at(1, 0, 8'hC0, "R7 disable forces txe");
        ctl_write(8'h00);
        tick();
        sts_read();
        expect_at(1, 0, 8'hC0, "R7 clear ignored");
        expect_at(1, 3, 8'h00, "R7 no start");
        sts_write(8'h7F);
        expect_at(2, 2, 8'h04, "R10 tx irq while off");
        ctl_write(8'h80);
        tick(4);

        if (q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL drain actual=%0d expected=0 pending", q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule